// File: doc/BRIEF.md
# Lock Acquisition Supervisor

This block decides when a serial transmitter may send payload. It watches a raw, cycle-by-cycle PLL lock indication and runs a four-state link bring-up sequence. First it waits until lock has held long enough to be trusted. It then holds off for a second programmable interval so that the far-end receiver can synchronise on idle symbols. After that it can spend one cycle sending the number of lock losses seen so far, and then it declares the link ready.

While the link is up, the block watches for lock loss in one of two ways. In hard mode a single bad cycle ends the link. In soft mode a programmable number of bad cycles is tolerated, and those bad cycles need not be consecutive. The bad-cycle tally is forgotten after a long unbroken run of good cycles. Every fall back to the out-of-lock state increments a saturating 8-bit loss counter. A force-lock control makes the block act as if lock were always present.

The state register is held in three copies that feed a majority vote. This protects against single upsets. All three copies are brought out beside the voted state code.

Top module: `lock_sup_top`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `state_code` is 00 (out-of-lock), `link_ready` is 0, `send_idle` is 1 and `loss_count` is 0. Reset never increments `loss_count`.
- R2: The state codes are: out-of-lock 00, locked 01, ready 10 and count-transmit 11. `link_ready` is 1 exactly when `state_code` is 10. `send_idle` is 1 exactly when `state_code` is 00 or 01.
- R3: In out-of-lock, the block enters locked on the clock edge that ends the m-th consecutive cycle with lock present, where m = 2^(`cfg_lock_time`+2). A cycle without lock restarts the run.
- R4: In locked, after n = 2^(`cfg_wait_time`) consecutive cycles with lock present, the block goes directly to ready when `cfg_count_en` is 0. A cycle without lock restarts this run.
- R5: With `cfg_count_en` = 1, the same completion of the wait run enters count-transmit (11) for exactly one cycle, and then ready. During that cycle `loss_count` holds the value to be sent.
- R6: Hard mode (`cfg_soft_en` = 0): one cycle without lock in locked, count-transmit or ready sends the block to out-of-lock on the next edge.
- R7: Soft mode (`cfg_soft_en` = 1): the block enters out-of-lock on the k-th cycle without lock, where k = 2^(`cfg_loss_tol`+1). These cycles are counted whether or not they are consecutive.
- R8: In soft mode, 1024 consecutive cycles with lock present clear the bad-cycle tally. A run of 1023 does not clear it.
- R9: `loss_count` increments by one on every transition into out-of-lock from another state and saturates at 255.
- R10: With `cfg_force_lock` = 1, the block treats lock as present on every cycle, whatever the value of `instant_lock`.
- R11: `state_copy_a`, `state_copy_b` and `state_copy_c` are the three stored state copies. `state_code` is their bitwise majority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instant_lock | input | 1 | Raw PLL lock indication, sampled every cycle |
| cfg_lock_time | input | 4 | Lock qualification exponent; m = 2^(value+2) |
| cfg_wait_time | input | 5 | Receiver wait exponent; n = 2^value |
| cfg_loss_tol | input | 3 | Soft loss tolerance exponent; k = 2^(value+1) |
| cfg_soft_en | input | 1 | 1 selects soft loss detection |
| cfg_count_en | input | 1 | 1 inserts the one-cycle count-transmit state |
| cfg_force_lock | input | 1 | 1 treats lock as always present |
| state_code | output | 2 | Voted state code |
| state_copy_a | output | 2 | Stored state copy A |
| state_copy_b | output | 2 | Stored state copy B |
| state_copy_c | output | 2 | Stored state copy C |
| link_ready | output | 1 | High only in ready |
| send_idle | output | 1 | High in out-of-lock and locked |
| loss_count | output | 8 | Saturating count of lock losses since reset |

## Verification
A qualification counter that is off by one moves the first appearance of 01, 10 or 11 on `state_code` by a cycle. That shift is visible on the edge where the transition is due. A bad-cycle tally that is cleared wrongly or never cleared shows up as a link that stays ready when it should drop, or drops when it should stay, on the single bad cycle that decides the case. A wrong loss counter or saturation shows directly on `loss_count` one cycle after each drop. A stuck state copy differs from the voted code at once on the copy outputs.

// File: rtl/lock_sup_pkg.sv
package lock_sup_pkg;

    localparam int LOCK_FW      = 4;
    localparam int WAIT_FW      = 5;
    localparam int TOL_FW       = 3;
    localparam int LOCK_OFS     = 2;
    localparam int TOL_OFS      = 1;
    localparam int NUM_COPIES   = 3;

    localparam int LOCK_EXP_MAX = (1 << LOCK_FW) - 1 + LOCK_OFS;
    localparam int WAIT_EXP_MAX = (1 << WAIT_FW) - 1;
    localparam int RUN_W        = ((LOCK_EXP_MAX > WAIT_EXP_MAX) ? LOCK_EXP_MAX : WAIT_EXP_MAX) + 1;
    localparam int TALLY_W      = (1 << TOL_FW) - 1 + TOL_OFS + 1;

    typedef enum logic [1:0] {
        ST_OOL    = 2'b00,
        ST_LOCKED = 2'b01,
        ST_READY  = 2'b10,
        ST_TXCNT  = 2'b11
    } link_st_e;

    typedef struct packed {
        logic [LOCK_FW-1:0] lock_time;
        logic [WAIT_FW-1:0] wait_time;
        logic [TOL_FW-1:0]  loss_tol;
        logic               soft_en;
        logic               count_en;
        logic               force_lock;
    } sup_cfg_t;

    // terminal value of the lock run counter: 2^(f+2) - 1
    function automatic logic [RUN_W-1:0] lock_terminal(input logic [LOCK_FW-1:0] f);
        return (RUN_W'(1) << (int'(f) + LOCK_OFS)) - RUN_W'(1);
    endfunction

    // terminal value of the wait run counter: 2^f - 1
    function automatic logic [RUN_W-1:0] wait_terminal(input logic [WAIT_FW-1:0] f);
        return (RUN_W'(1) << int'(f)) - RUN_W'(1);
    endfunction

    // terminal value of the bad-cycle tally: 2^(f+1) - 1
    function automatic logic [TALLY_W-1:0] tol_terminal(input logic [TOL_FW-1:0] f);
        return (TALLY_W'(1) << (int'(f) + TOL_OFS)) - TALLY_W'(1);
    endfunction

    function automatic logic [1:0] majority3(input logic [1:0] a,
                                             input logic [1:0] b,
                                             input logic [1:0] c);
        return (a & b) | (b & c) | (a & c);
    endfunction

endpackage

// File: rtl/lock_sup_run_ctr.sv
module lock_sup_run_ctr #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         inc,
    input  logic [W-1:0] terminal,
    output logic         hit
);

    logic [W-1:0] run_q;

    assign hit = inc && !clear && (run_q == terminal);

    always_ff @(posedge clk) begin
        if (rst || clear || hit) begin
            run_q <= '0;
        end else if (inc) begin
            run_q <= run_q + W'(1);
        end
    end

endmodule

// File: rtl/lock_sup_soft_mon.sv
module lock_sup_soft_mon #(
    parameter int GOOD_RUN = 1024,
    parameter int TW       = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          active,
    input  logic          lock_ok,
    input  logic          soft_en,
    input  logic [TW-1:0] tol_term,
    output logic          loss
);

    localparam int GW = (GOOD_RUN > 1) ? $clog2(GOOD_RUN) : 1;
    localparam logic [GW-1:0] GOOD_TERM = GW'(GOOD_RUN - 1);

    logic [TW-1:0] tally_q;
    logic [GW-1:0] good_q;
    logic          tally_full;

    assign tally_full = (tally_q == tol_term);
    assign loss       = active && !lock_ok && (!soft_en || tally_full);

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            tally_q <= '0;
            good_q  <= '0;
        end else if (!lock_ok) begin
            good_q  <= '0;
            tally_q <= loss ? '0 : tally_q + TW'(1);
        end else if (good_q == GOOD_TERM) begin
            good_q  <= '0;
            tally_q <= '0;
        end else begin
            good_q  <= good_q + GW'(1);
        end
    end

endmodule

// File: rtl/lock_sup_tmr_state.sv
module lock_sup_tmr_state
    import lock_sup_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  link_st_e   next_st,
    output link_st_e   voted_st,
    output logic [1:0] copy_a,
    output logic [1:0] copy_b,
    output logic [1:0] copy_c
);

    logic [1:0] copy_q [NUM_COPIES];

    for (genvar g = 0; g < NUM_COPIES; g++) begin : g_copy
        always_ff @(posedge clk) begin
            if (rst) begin
                copy_q[g] <= ST_OOL;
            end else begin
                copy_q[g] <= next_st;
            end
        end
    end

    assign copy_a   = copy_q[0];
    assign copy_b   = copy_q[1];
    assign copy_c   = copy_q[2];
    assign voted_st = link_st_e'(majority3(copy_q[0], copy_q[1], copy_q[2]));

endmodule

// File: rtl/lock_sup_loss_ctr.sv
module lock_sup_loss_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         event_in,
    output logic [W-1:0] count
);

    localparam logic [W-1:0] FULL = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (event_in && (count != FULL)) begin
            count <= count + W'(1);
        end
    end

endmodule

// File: rtl/lock_sup_top.sv
module lock_sup_top
    import lock_sup_pkg::*;
#(
    parameter int GOOD_RUN = 1024,
    parameter int LOSS_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              instant_lock,
    input  logic [3:0]        cfg_lock_time,
    input  logic [4:0]        cfg_wait_time,
    input  logic [2:0]        cfg_loss_tol,
    input  logic              cfg_soft_en,
    input  logic              cfg_count_en,
    input  logic              cfg_force_lock,
    output logic [1:0]        state_code,
    output logic [1:0]        state_copy_a,
    output logic [1:0]        state_copy_b,
    output logic [1:0]        state_copy_c,
    output logic              link_ready,
    output logic              send_idle,
    output logic [LOSS_W-1:0] loss_count
);

    sup_cfg_t         cfg;
    link_st_e         cur_st;
    link_st_e         nxt_st;
    logic             lock_ok;
    logic             in_qual;
    logic             qual_hit;
    logic             loss;
    logic [RUN_W-1:0] run_term;

    assign cfg = '{lock_time:  cfg_lock_time,
                   wait_time:  cfg_wait_time,
                   loss_tol:   cfg_loss_tol,
                   soft_en:    cfg_soft_en,
                   count_en:   cfg_count_en,
                   force_lock: cfg_force_lock};

    assign lock_ok  = instant_lock || cfg.force_lock;
    assign in_qual  = (cur_st == ST_OOL) || (cur_st == ST_LOCKED);
    assign run_term = (cur_st == ST_OOL) ? lock_terminal(cfg.lock_time)
                                         : wait_terminal(cfg.wait_time);

    lock_sup_run_ctr #(.W(RUN_W)) run_i (
        .clk      (clk),
        .rst      (rst),
        .clear    (!in_qual || !lock_ok),
        .inc      (in_qual && lock_ok),
        .terminal (run_term),
        .hit      (qual_hit)
    );

    lock_sup_soft_mon #(.GOOD_RUN(GOOD_RUN), .TW(TALLY_W)) mon_i (
        .clk      (clk),
        .rst      (rst),
        .active   (cur_st != ST_OOL),
        .lock_ok  (lock_ok),
        .soft_en  (cfg.soft_en),
        .tol_term (tol_terminal(cfg.loss_tol)),
        .loss     (loss)
    );

    always_comb begin
        nxt_st = cur_st;
        unique case (cur_st)
            ST_OOL: begin
                if (qual_hit) nxt_st = ST_LOCKED;
            end
            ST_LOCKED: begin
                if (loss)          nxt_st = ST_OOL;
                else if (qual_hit) nxt_st = cfg.count_en ? ST_TXCNT : ST_READY;
            end
            ST_TXCNT: begin
                nxt_st = loss ? ST_OOL : ST_READY;
            end
            ST_READY: begin
                if (loss) nxt_st = ST_OOL;
            end
            default: nxt_st = ST_OOL;
        endcase
    end

    lock_sup_tmr_state st_i (
        .clk      (clk),
        .rst      (rst),
        .next_st  (nxt_st),
        .voted_st (cur_st),
        .copy_a   (state_copy_a),
        .copy_b   (state_copy_b),
        .copy_c   (state_copy_c)
    );

    lock_sup_loss_ctr #(.W(LOSS_W)) loss_i (
        .clk      (clk),
        .rst      (rst),
        .event_in (loss),
        .count    (loss_count)
    );

    assign state_code = cur_st;
    assign link_ready = (cur_st == ST_READY);
    assign send_idle  = in_qual;

endmodule

// File: rtl/lock_sup_chk.sv
module lock_sup_chk (
    input logic       clk,
    input logic       rst,
    input logic       instant_lock,
    input logic       cfg_soft_en,
    input logic       cfg_count_en,
    input logic       cfg_force_lock,
    input logic [1:0] state_code,
    input logic [1:0] state_copy_a,
    input logic [1:0] state_copy_b,
    input logic [1:0] state_copy_c,
    input logic       link_ready,
    input logic       send_idle,
    input logic [7:0] loss_count
);

    // R2
    ready_not_idle_chk: assert property (@(posedge clk) disable iff (rst)
        link_ready |-> !send_idle);

    // R4
    no_tx_when_disabled_chk: assert property (@(posedge clk) disable iff (rst)
        (state_code == 2'b01 && !cfg_count_en) |=> (state_code != 2'b11));

    // R5
    tx_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        (state_code == 2'b11) |=> (state_code != 2'b11));

    // R6
    hard_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg_soft_en && !cfg_force_lock && !instant_lock && state_code != 2'b00)
        |=> (state_code == 2'b00));

    // R9
    loss_step_chk: assert property (@(posedge clk) disable iff (rst)
        (state_code == 2'b00 && $past(state_code) != 2'b00)
        |-> (loss_count == (($past(loss_count) == 8'hFF) ? 8'hFF : ($past(loss_count) + 8'd1))));

    // R9
    loss_monotonic_chk: assert property (@(posedge clk) disable iff (rst)
        loss_count >= $past(loss_count));

    // R10
    force_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_force_lock && state_code != 2'b00) |=> (state_code != 2'b00));

    // R11
    copies_agree_chk: assert property (@(posedge clk) disable iff (rst)
        (state_copy_a == state_copy_b) && (state_copy_b == state_copy_c)
        && (state_code == state_copy_a));

endmodule

bind lock_sup_top lock_sup_chk chk_i (
    .clk            (clk),
    .rst            (rst),
    .instant_lock   (instant_lock),
    .cfg_soft_en    (cfg_soft_en),
    .cfg_count_en   (cfg_count_en),
    .cfg_force_lock (cfg_force_lock),
    .state_code     (state_code),
    .state_copy_a   (state_copy_a),
    .state_copy_b   (state_copy_b),
    .state_copy_c   (state_copy_c),
    .link_ready     (link_ready),
    .send_idle      (send_idle),
    .loss_count     (loss_count)
);

// File: tb/lock_sup_top_tb_top.sv
module lock_sup_top_tb_top;

    localparam int CLK_HALF = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       instant_lock = 1'b0;
    logic [3:0] cfg_lock_time = '0;
    logic [4:0] cfg_wait_time = '0;
    logic [2:0] cfg_loss_tol = '0;
    logic       cfg_soft_en = 1'b0;
    logic       cfg_count_en = 1'b0;
    logic       cfg_force_lock = 1'b0;
    logic [1:0] state_code;
    logic [1:0] state_copy_a;
    logic [1:0] state_copy_b;
    logic [1:0] state_copy_c;
    logic       link_ready;
    logic       send_idle;
    logic [7:0] loss_count;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #CLK_HALF clk = ~clk;

    lock_sup_top dut_i (
        .clk            (clk),
        .rst            (rst),
        .instant_lock   (instant_lock),
        .cfg_lock_time  (cfg_lock_time),
        .cfg_wait_time  (cfg_wait_time),
        .cfg_loss_tol   (cfg_loss_tol),
        .cfg_soft_en    (cfg_soft_en),
        .cfg_count_en   (cfg_count_en),
        .cfg_force_lock (cfg_force_lock),
        .state_code     (state_code),
        .state_copy_a   (state_copy_a),
        .state_copy_b   (state_copy_b),
        .state_copy_c   (state_copy_c),
        .link_ready     (link_ready),
        .send_idle      (send_idle),
        .loss_count     (loss_count)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input logic lk);
        instant_lock = lk;
        @(posedge clk);
        @(negedge clk);
    endtask

    // output consistency for the present state (R2, R11)
    task automatic chk_outputs();
        chk("R2 link_ready", int'(link_ready), int'(state_code == 2'b10));
        chk("R2 send_idle", int'(send_idle), int'(state_code == 2'b00 || state_code == 2'b01));
        chk("R11 copy a", int'(state_copy_a), int'(state_code));
        chk("R11 copy b", int'(state_copy_b), int'(state_code));
        chk("R11 copy c", int'(state_copy_c), int'(state_code));
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) step(1'b0);
        chk("R1 state in reset", int'(state_code), 0);
        chk("R1 ready in reset", int'(link_ready), 0);
        chk("R1 idle in reset", int'(send_idle), 1);
        chk("R1 count in reset", int'(loss_count), 0);
        rst = 1'b0;
    endtask

    // sweep of acquisition timing (R3, R4, R5)
    task automatic acquire_case(input int lf, input int wf, input bit ce);
        int m;
        int n;
        int t_lock;
        int t_tx;
        int t_ready;
        m = 1 << (lf + 2);
        n = 1 << wf;
        cfg_lock_time = 4'(lf);
        cfg_wait_time = 5'(wf);
        cfg_count_en  = ce;
        cfg_soft_en   = 1'b0;
        cfg_force_lock = 1'b0;
        do_reset();
        t_lock = 0;
        t_tx = 0;
        t_ready = 0;
        for (int cyc = 1; cyc <= m + n + 3; cyc++) begin
            step(1'b1);
            chk_outputs();
            if (state_code == 2'b01 && t_lock == 0) t_lock = cyc;
            if (state_code == 2'b11 && t_tx == 0) t_tx = cyc;
            if (state_code == 2'b10 && t_ready == 0) t_ready = cyc;
            if (state_code == 2'b11) chk("R5 count during tx", int'(loss_count), 0);
        end
        chk("R3 lock entry cycle", t_lock, m);
        if (ce) begin
            chk("R5 tx entry cycle", t_tx, m + n);
            chk("R5 ready after tx", t_ready, m + n + 1);
        end else begin
            chk("R4 tx not entered", t_tx, 0);
            chk("R4 ready entry cycle", t_ready, m + n);
        end
        chk("R9 no loss during acquire", int'(loss_count), 0);
    endtask

    initial begin
        @(negedge clk);

        // R3, R4, R5 sweep
        for (int lf = 0; lf < 4; lf++)
            for (int wf = 0; wf < 3; wf++)
                for (int ce = 0; ce < 2; ce++)
                    acquire_case(lf, wf, ce[0]);

        // R3: a missing-lock cycle restarts qualification (m = 4)
        cfg_lock_time = 4'd0; cfg_wait_time = 5'd0; cfg_count_en = 1'b0;
        do_reset();
        repeat (3) step(1'b1);
        step(1'b0);
        chk("R3 run restarted", int'(state_code), 0);
        repeat (3) step(1'b1);
        chk("R3 three good after restart", int'(state_code), 0);
        step(1'b1);
        chk("R3 locked after four good", int'(state_code), 1);

        // R4: a missing-lock cycle in locked under hard mode drops; R6
        step(1'b0);
        chk("R6 drop from locked", int'(state_code), 0);
        chk("R9 count after first loss", int'(loss_count), 1);

        // R6: drop from ready
        repeat (5) step(1'b1);
        chk("R6 ready reached", int'(state_code), 2);
        step(1'b0);
        chk("R6 drop from ready", int'(state_code), 0);
        chk("R9 count after second loss", int'(loss_count), 2);

        // R1: reset clears count and is not counted
        repeat (5) step(1'b1);
        do_reset();
        step(1'b1);
        chk("R1 count after reset", int'(loss_count), 0);
        chk("R1 state after reset", int'(state_code), 0);

        // R6: drop from count-transmit
        cfg_count_en = 1'b1;
        do_reset();
        repeat (5) step(1'b1);
        chk("R5 tx reached", int'(state_code), 3);
        step(1'b0);
        chk("R6 drop from tx", int'(state_code), 0);
        cfg_count_en = 1'b0;

        // R7: soft mode, k = 4 with scattered bad cycles
        cfg_soft_en = 1'b1; cfg_loss_tol = 3'd1;
        do_reset();
        repeat (5) step(1'b1);
        for (int b = 1; b <= 3; b++) begin
            step(1'b0);
            chk("R7 tolerated bad cycle", int'(state_code), 2);
            repeat (b * 7) step(1'b1);
        end
        step(1'b0);
        chk("R7 drop on fourth bad", int'(state_code), 0);
        chk("R9 soft loss counted", int'(loss_count), 1);

        // R7: consecutive bad cycles, k = 2
        cfg_loss_tol = 3'd0;
        do_reset();
        repeat (5) step(1'b1);
        step(1'b0);
        chk("R7 first of two bad", int'(state_code), 2);
        step(1'b0);
        chk("R7 second of two bad", int'(state_code), 0);

        // R8: 1024 good cycles clear the tally, 1023 do not (k = 2)
        do_reset();
        repeat (5) step(1'b1);
        step(1'b0);
        repeat (1024) step(1'b1);
        step(1'b0);
        chk("R8 tally cleared by 1024 good", int'(state_code), 2);
        repeat (1023) step(1'b1);
        step(1'b0);
        chk("R8 tally kept after 1023 good", int'(state_code), 0);
        cfg_soft_en = 1'b0;

        // R9: saturation at 255
        do_reset();
        for (int i = 1; i <= 260; i++) begin
            repeat (5) step(1'b1);
            step(1'b0);
            if (i == 1 || i == 254 || i == 255 || i == 256 || i == 260)
                chk("R9 saturating count", int'(loss_count), (i > 255) ? 255 : i);
        end
        chk("R9 state after last loss", int'(state_code), 0);

        // R10: force lock with instant_lock low (m = 8, n = 2)
        cfg_force_lock = 1'b1; cfg_lock_time = 4'd1; cfg_wait_time = 5'd1;
        do_reset();
        repeat (9) step(1'b0);
        chk("R10 locked not yet ready", int'(state_code), 1);
        step(1'b0);
        chk("R10 ready with forced lock", int'(state_code), 2);
        repeat (50) step(1'b0);
        chk("R10 stays ready", int'(state_code), 2);
        chk("R10 no loss counted", int'(loss_count), 0);
        chk_outputs();
        cfg_force_lock = 1'b0;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule